// File: doc/BRIEF.md
# Instruction Length Predecoder

This block sits between an instruction fetch buffer and the decode stage of a core whose instruction stream is always big-endian. The fetch buffer shows it the first two bytes at the current fetch offset and says how many bytes from that offset are valid. The block reads a 5-bit escape prefix from the top of that halfword. Three bits are the major-opcode row and two are sub-bits. From the prefix it picks a length class: 16-bit compressed, 48-bit prefixed, 64-bit prefixed, variable-length block, or ordinary 32-bit. It reports the class, the byte length and the 11 bits that follow the prefix.

The block owns the fetch offset. It moves the offset forward by the decoded length in each cycle that it produces a complete instruction. A variable-length block carries no length in its prefix, so the block flags it and holds the offset. It moves on only when an outside length is supplied. The escape row is honoured only while escape decoding is enabled. Little-endian instruction mode is refused with an error, and nothing is decoded in that mode.

Top module: `ilp_top`

## Requirements
- R1: When the top three bits of the halfword are not 000, the class is ordinary (code 0), the byte length is 4 and the payload output is zero.
- R2: The halfword is {first stream byte, second stream byte}, where head_i[15:8] is the first byte. With escape decoding enabled, prefix head_i[15:11] = 00000 gives class compressed (code 1) and length 2. The payload output is head_i[10:0].
- R3: Prefix 00001 gives class 48-bit prefixed (code 2), length 6 and payload head_i[10:0].
- R4: Prefix 00010 gives class 64-bit prefixed (code 3), length 8 and payload head_i[10:0].
- R5: Prefix 00011 gives class variable block (code 4), byte length 0, vblk_o high and payload head_i[10:0].
- R6: With escape decoding disabled, a 000 row decodes as ordinary 32-bit: class 0, length 4, payload zero.
- R7: If the valid byte count is below the bytes the class needs, inst_vld_o is low. The class, length, payload and vblk_o outputs are zero, and the offset holds. The count needed is the length, or 2 for a variable block.
- R8: After a cycle with a valid non-block instruction, the offset has grown by the byte length, modulo 2^OFS_W.
- R9: On a valid variable block, the offset holds unless ext_len_vld_i is high, and then it grows by ext_len_i. ext_len_i has no effect in any other cycle.
- R10: While le_mode_i is high, illegal_o is high, inst_vld_o and vblk_o are low, all decode outputs are zero and the offset holds.
- R11: Under reset the offset is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| head_i | input | 16 | First two bytes at the fetch offset, first byte in [15:8] |
| vld_cnt_i | input | CNT_W | Valid bytes from the offset onward |
| esc_en_i | input | 1 | Escape-row decoding enable |
| le_mode_i | input | 1 | Little-endian instruction mode request (illegal) |
| ext_len_vld_i | input | 1 | External length for a variable block is present |
| ext_len_i | input | EXT_W | External byte length for a variable block |
| inst_vld_o | output | 1 | A complete instruction is classified |
| cls_o | output | 3 | Length class code |
| byte_len_o | output | 4 | Instruction length in bytes |
| payload_o | output | 11 | Bits after the escape prefix |
| vblk_o | output | 1 | Variable block waiting for a length |
| illegal_o | output | 1 | Illegal instruction byte-order mode |
| offset_o | output | OFS_W | Current fetch offset |

## Verification
The bench sweeps all 32 prefixes against every valid byte count from 0 to 8, in both escape settings and both byte-order modes. This catches a design that takes the escape row while it is disabled, or that swaps the sub-bit decoding between the 48- and 64-bit classes. It also catches a compare that is off by one at the exact-fit byte count, which would advance the offset on a truncated instruction. The external length is toggled on every class. A design that applies it outside a variable block, or that moves the offset on a block with no length given, shows up as a drift in the tracked offset. The offset also wraps during the run, which exposes a truncated or saturating adder.

// File: rtl/ilp_pkg.sv
package ilp_pkg;
  typedef enum logic [2:0] {
    CLS_I32  = 3'd0,
    CLS_C16  = 3'd1,
    CLS_P48  = 3'd2,
    CLS_P64  = 3'd3,
    CLS_VBLK = 3'd4
  } ilp_cls_e;

  localparam int PFX_W = 5;
  localparam int PAY_W = 11;
  localparam int LEN_W = 4;
endpackage

// File: rtl/ilp_classify.sv
module ilp_classify
  import ilp_pkg::*;
(
  input  logic [15:0]      hword_i,
  input  logic             esc_en_i,
  output ilp_cls_e         cls_o,
  output logic [LEN_W-1:0] len_o,
  output logic [LEN_W-1:0] need_o,
  output logic [PAY_W-1:0] payload_o
);
  logic [PFX_W-1:0] pfx;
  assign pfx = hword_i[15:16-PFX_W];

  always_comb begin
    cls_o     = CLS_I32;
    len_o     = LEN_W'(4);
    need_o    = LEN_W'(4);
    payload_o = '0;
    if (esc_en_i && pfx[4:2] == 3'b000) begin
      payload_o = hword_i[PAY_W-1:0];
      unique case (pfx[1:0])
        2'b00: begin cls_o = CLS_C16;  len_o = LEN_W'(2); need_o = LEN_W'(2); end
        2'b01: begin cls_o = CLS_P48;  len_o = LEN_W'(6); need_o = LEN_W'(6); end
        2'b10: begin cls_o = CLS_P64;  len_o = LEN_W'(8); need_o = LEN_W'(8); end
        default: begin cls_o = CLS_VBLK; len_o = '0; need_o = LEN_W'(2); end
      endcase
    end
  end

  // R2 R3 R4 R5: only even lengths up to 8 exist
  always_comb begin
    a_r5_len_legal: assert (len_o inside {4'd0, 4'd2, 4'd4, 4'd6, 4'd8});
  end
endmodule

// File: rtl/ilp_gate.sv
module ilp_gate
  import ilp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  ilp_cls_e         cls_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] need_i,
  input  logic [PAY_W-1:0] payload_i,
  input  logic [CNT_W-1:0] vld_cnt_i,
  input  logic             le_mode_i,
  output logic             inst_vld_o,
  output logic             vblk_o,
  output logic             illegal_o,
  output ilp_cls_e         cls_o,
  output logic [LEN_W-1:0] len_o,
  output logic [PAY_W-1:0] payload_o
);
  logic enough;
  assign enough     = int'(vld_cnt_i) >= int'(need_i);
  assign illegal_o  = le_mode_i;
  assign inst_vld_o = !le_mode_i && enough;
  assign vblk_o     = inst_vld_o && (cls_i == CLS_VBLK);
  assign cls_o      = inst_vld_o ? cls_i : CLS_I32;
  assign len_o      = inst_vld_o ? len_i : '0;
  assign payload_o  = inst_vld_o ? payload_i : '0;

  // R10: an illegal mode never coexists with a decode
  always_comb begin
    a_r10_exclusive: assert (!(illegal_o && (inst_vld_o || vblk_o)));
  end
endmodule

// File: rtl/ilp_offset.sv
module ilp_offset
  import ilp_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int EXT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inst_vld_i,
  input  logic             vblk_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             ext_vld_i,
  input  logic [EXT_W-1:0] ext_len_i,
  output logic [OFS_W-1:0] offset_o
);
  logic [OFS_W-1:0] offset_q, step;

  always_comb begin
    step = '0;
    if (inst_vld_i) begin
      if (!vblk_i)        step = OFS_W'(len_i);
      else if (ext_vld_i) step = OFS_W'(ext_len_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) offset_q <= '0;
    else         offset_q <= offset_q + step;
  end

  assign offset_o = offset_q;

  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inst_vld_i |=> $stable(offset_q));
  a_r9_vblk_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vblk_i && !ext_vld_i) |=> $stable(offset_q));
  a_r8_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_vld_i && !vblk_i) |=> (offset_q - $past(offset_q)) == OFS_W'($past(len_i)));
endmodule

// File: rtl/ilp_top.sv
module ilp_top
  import ilp_pkg::*;
#(
  parameter int WIN_BYTES = 8,
  parameter int OFS_W     = 16,
  parameter int EXT_W     = 8,
  localparam int CNT_W    = $clog2(WIN_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      head_i,
  input  logic [CNT_W-1:0] vld_cnt_i,
  input  logic             esc_en_i,
  input  logic             le_mode_i,
  input  logic             ext_len_vld_i,
  input  logic [EXT_W-1:0] ext_len_i,
  output logic             inst_vld_o,
  output logic [2:0]       cls_o,
  output logic [3:0]       byte_len_o,
  output logic [10:0]      payload_o,
  output logic             vblk_o,
  output logic             illegal_o,
  output logic [OFS_W-1:0] offset_o
);
  ilp_cls_e         raw_cls, gate_cls;
  logic [LEN_W-1:0] raw_len, raw_need, gate_len;
  logic [PAY_W-1:0] raw_pay, gate_pay;
  logic             vld, vblk;

  ilp_classify u_classify (
    .hword_i   (head_i),
    .esc_en_i  (esc_en_i),
    .cls_o     (raw_cls),
    .len_o     (raw_len),
    .need_o    (raw_need),
    .payload_o (raw_pay)
  );

  ilp_gate #(.CNT_W(CNT_W)) u_gate (
    .cls_i      (raw_cls),
    .len_i      (raw_len),
    .need_i     (raw_need),
    .payload_i  (raw_pay),
    .vld_cnt_i  (vld_cnt_i),
    .le_mode_i  (le_mode_i),
    .inst_vld_o (vld),
    .vblk_o     (vblk),
    .illegal_o  (illegal_o),
    .cls_o      (gate_cls),
    .len_o      (gate_len),
    .payload_o  (gate_pay)
  );

  ilp_offset #(.OFS_W(OFS_W), .EXT_W(EXT_W)) u_offset (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inst_vld_i (vld),
    .vblk_i     (vblk),
    .len_i      (gate_len),
    .ext_vld_i  (ext_len_vld_i),
    .ext_len_i  (ext_len_i),
    .offset_o   (offset_o)
  );

  assign inst_vld_o = vld;
  assign vblk_o     = vblk;
  assign cls_o      = gate_cls;
  assign byte_len_o = gate_len;
  assign payload_o  = gate_pay;

  a_r7_len_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inst_vld_o |-> int'(byte_len_o) <= int'(vld_cnt_i));
  a_r10_le_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_mode_i |=> $stable(offset_o));
endmodule

// File: tb/ilp_top_tb.sv
module ilp_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] head_i = '0;
  logic [3:0]  vld_cnt_i = '0;
  logic        esc_en_i = 1'b0, le_mode_i = 1'b0, ext_len_vld_i = 1'b0;
  logic [7:0]  ext_len_i = '0;
  logic        inst_vld_o, vblk_o, illegal_o;
  logic [2:0]  cls_o;
  logic [3:0]  byte_len_o;
  logic [10:0] payload_o;
  logic [15:0] offset_o;

  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #10 clk_i = ~clk_i;

  ilp_top u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog act=1 exp=0");
    finish_run();
  end

  initial begin
    logic [15:0] exp_ofs;
    int iter;
    exp_ofs = '0;
    iter = 0;
    repeat (3) @(posedge clk_i);
    #1 chk("R11 reset offset", int'(offset_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    for (int le = 0; le < 2; le++)
      for (int esc = 0; esc < 2; esc++)
        for (int pfx = 0; pfx < 32; pfx++)
          for (int cnt = 0; cnt <= 8; cnt++) begin
            int e_cls, e_len, e_need, e_pay, e_vld, e_vblk, step;
            logic [10:0] pay;
            string tag;
            @(negedge clk_i);
            pay = 11'((iter * 421 + 5) & 11'h7ff);
            head_i = {5'(pfx), pay};
            vld_cnt_i = 4'(cnt);
            esc_en_i = 1'(esc);
            le_mode_i = 1'(le);
            ext_len_vld_i = 1'(iter & 1);
            ext_len_i = 8'((iter * 7 + 3) & 8'hff);
            if (esc != 0 && (pfx >> 2) == 0) begin
              e_pay = int'(pay);
              case (pfx & 3)
                0: begin e_cls = 1; e_len = 2; e_need = 2; tag = "R2"; end
                1: begin e_cls = 2; e_len = 6; e_need = 6; tag = "R3"; end
                2: begin e_cls = 3; e_len = 8; e_need = 8; tag = "R4"; end
                default: begin e_cls = 4; e_len = 0; e_need = 2; tag = "R5"; end
              endcase
            end else begin
              e_cls = 0; e_len = 4; e_need = 4; e_pay = 0;
              tag = ((pfx >> 2) == 0) ? "R6" : "R1";
            end
            e_vld = (le == 0 && cnt >= e_need) ? 1 : 0;
            if (le != 0) tag = "R10";
            else if (e_vld == 0) tag = "R7";
            if (e_vld == 0) begin e_cls = 0; e_len = 0; e_pay = 0; end
            e_vblk = (e_vld != 0 && e_cls == 4) ? 1 : 0;
            step = 0;
            if (e_vld != 0) begin
              if (e_vblk == 0) step = e_len;
              else if ((iter & 1) != 0) step = int'(ext_len_i);
            end
            #1;
            chk({tag, " inst_vld"}, int'(inst_vld_o), e_vld);
            chk({tag, " class"}, int'(cls_o), e_cls);
            chk({tag, " length"}, int'(byte_len_o), e_len);
            chk({tag, " payload"}, int'(payload_o), e_pay);
            chk({tag, " R5 vblk"}, int'(vblk_o), e_vblk);
            chk({tag, " R10 illegal"}, int'(illegal_o), le);
            exp_ofs = exp_ofs + 16'(step);
            @(posedge clk_i);
            #1 chk(e_vblk != 0 ? "R9 offset" : "R8 offset", int'(offset_o), int'(exp_ofs));
            iter++;
          end
    // R8: force wrap of the offset with back-to-back 8-byte instructions
    @(negedge clk_i);
    head_i = 16'h1000; vld_cnt_i = 4'd8; esc_en_i = 1'b1; le_mode_i = 1'b0;
    ext_len_vld_i = 1'b1; ext_len_i = 8'hff;
    for (int k = 0; k < 9000; k++) begin
      @(posedge clk_i);
      exp_ofs = exp_ofs + 16'd8;
    end
    #1 chk("R8 wrap offset", int'(offset_o), int'(exp_ofs));
    @(negedge clk_i) rst_ni = 1'b0;
    #1 chk("R11 reset clears offset", int'(offset_o), 0);
    finish_run();
  end
endmodule